// File: doc/BRIEF.md
# Six-Channel Triggered-Update PWM

This block produces six pulse-width modulated outputs from a small register file reached through a word-addressed read/write strobe interface. For each channel, software sets a clock prescaler, a period count, a high-time count and a polarity bit. These writes land in shadow storage only. The running waveform keeps its old settings until the channel's trigger bit rises.

On that rise the shadow settings are captured into a staging copy. With the smooth bit clear, the staging copy becomes active after a fixed number of clocks. With the smooth bit set, it becomes active when the running period ends, so the output has no partial period. A channel whose trigger and smooth bits are both low is forced high. There is no enable bit. A zero high-time count gives a quiet channel.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero, `rdata` is zero and every `pwm_out` bit is 1.
- R2: The register map uses word addresses. Word 0 is control: bit c is trigger, bit 8+c is polarity, bit 16+c is a stored output-type bit with no effect on the output, and bit 24+c is smooth. Word 1 holds the prescale of channel c in bits [4c+2:4c]. Word 2+2c is the 24-bit period count of channel c and word 3+2c is its 24-bit high count. A read returns the shadow value on `rdata` one clock after `rd_en`. Unimplemented bits and unmapped words read 0, and `rdata` is 0 in any cycle that follows a clock without `rd_en`.
- R3: Writes to prescale, period, high count or polarity do not change a channel's output before that channel's trigger bit rises.
- R4: If a write sets trigger (0 to 1) with smooth 0 at clock edge E, the output still shows the old settings at the sample after edge E+LAT+1 and shows the new waveform from the sample after edge E+LAT+2. LAT is a parameter, default 8.
- R5: If trigger rises while smooth is 1, the new settings take over at the clock edge that ends the running period. The output shows them from the following sample.
- R6: When a channel's trigger and smooth bits are both 0, its output is 1 from the second clock edge after the write onward.
- R7: With prescale P, period count N ≥ 2 and high count D, the raw waveform is active for the first (P+1)·D clocks of each (P+1)·N clock period. The first period starts at the commit.
- R8: A high count of 0 keeps the raw waveform inactive. A high count ≥ the period count keeps it active.
- R9: A period count below 2 keeps the raw waveform inactive.
- R10: Polarity 1 drives the raw waveform (active = high). Polarity 0 drives its complement.
- R11: Writing and triggering one channel does not alter any other channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_out | output | 6 | Channel outputs, bit c is channel c |

## Verification
A smooth-mode commit and the natural wrap of the period counter land on the same clock edge. The design must load the new settings and restart the count at that edge rather than wrap into the old period. The bench provokes this on a channel that is constantly high with period 8 and queues a zero high count in smooth mode. It then computes from the period arithmetic which sample must still be high and which must be the first low one. A second collision, a trigger rise in the cycle a pending commit would fire, is settled in favour of the rise.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int CNT_W  = 24;
  localparam int PS_W   = 3;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [PS_W-1:0]  pscale;
    logic [CNT_W-1:0] span;
    logic [CNT_W-1:0] hi;
    logic             pol_norm;
  } wave_cfg_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 6,
  parameter int AW  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [AW-1:0]         addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output wave_cfg_t [NCH-1:0]   cfg,
  output logic [NCH-1:0]        trig,
  output logic [NCH-1:0]        smooth
);
  logic [NCH-1:0]   trig_r, pol_r, drive_r, smooth_r;
  logic [PS_W-1:0]  ps_r   [NCH];
  logic [CNT_W-1:0] per_r  [NCH];
  logic [CNT_W-1:0] duty_r [NCH];
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_r   <= '0;
      pol_r    <= '0;
      drive_r  <= '0;
      smooth_r <= '0;
      for (int c = 0; c < NCH; c++) begin
        ps_r[c]   <= '0;
        per_r[c]  <= '0;
        duty_r[c] <= '0;
      end
    end else if (wr_en) begin
      if (addr == '0) begin
        trig_r   <= wdata[NCH-1:0];
        pol_r    <= wdata[8 +: NCH];
        drive_r  <= wdata[16 +: NCH];
        smooth_r <= wdata[24 +: NCH];
      end else if (addr == AW'(1)) begin
        for (int c = 0; c < NCH; c++) ps_r[c] <= wdata[4*c +: PS_W];
      end else begin
        for (int c = 0; c < NCH; c++) begin
          if (addr == AW'(2 + 2*c)) per_r[c]  <= wdata[CNT_W-1:0];
          if (addr == AW'(3 + 2*c)) duty_r[c] <= wdata[CNT_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == '0) begin
      rd_mux[NCH-1:0]   = trig_r;
      rd_mux[8 +: NCH]  = pol_r;
      rd_mux[16 +: NCH] = drive_r;
      rd_mux[24 +: NCH] = smooth_r;
    end else if (addr == AW'(1)) begin
      for (int c = 0; c < NCH; c++) rd_mux[4*c +: PS_W] = ps_r[c];
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (addr == AW'(2 + 2*c)) rd_mux[CNT_W-1:0] = per_r[c];
        if (addr == AW'(3 + 2*c)) rd_mux[CNT_W-1:0] = duty_r[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      cfg[c].pscale   = ps_r[c];
      cfg[c].span     = per_r[c];
      cfg[c].hi       = duty_r[c];
      cfg[c].pol_norm = pol_r[c];
    end
  end

  assign trig   = trig_r;
  assign smooth = smooth_r;
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int LAT = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  wave_cfg_t shadow,
  input  logic      trig,
  input  logic      smooth,
  output logic      pwm_o
);
  localparam int LW = (LAT > 1) ? $clog2(LAT) : 1;

  logic             trig_q;
  wave_cfg_t        staged, act;
  logic             pend_fast, pend_slow;
  logic [LW-1:0]    wait_cnt;
  logic [PS_W-1:0]  pre;
  logic [CNT_W-1:0] pos;
  logic rise, running, tick, last, commit_go, wave;

  assign rise      = trig & ~trig_q;
  assign running   = act.span >= CNT_W'(2);
  assign tick      = pre == act.pscale;
  assign last      = tick && (pos == act.span - CNT_W'(1));
  // a new rise supersedes a commit that would fire in the same cycle
  assign commit_go = ~rise & ((pend_fast && wait_cnt == '0) ||
                              (pend_slow && (last || !running)));
  assign wave      = running && (pos < act.hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q    <= 1'b0;
      staged    <= '0;
      pend_fast <= 1'b0;
      pend_slow <= 1'b0;
      wait_cnt  <= '0;
    end else begin
      trig_q <= trig;
      if (rise) begin
        staged    <= shadow;
        pend_fast <= ~smooth;
        pend_slow <= smooth;
        wait_cnt  <= LW'(LAT - 1);
      end else if (commit_go) begin
        pend_fast <= 1'b0;
        pend_slow <= 1'b0;
      end else if (pend_fast && wait_cnt != '0) begin
        wait_cnt <= wait_cnt - LW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= '0;
      pre <= '0;
      pos <= '0;
    end else if (commit_go) begin
      act <= staged;
      pre <= '0;
      pos <= '0;
    end else if (!running) begin
      pre <= '0;
      pos <= '0;
    end else if (tick) begin
      pre <= '0;
      pos <= last ? '0 : pos + CNT_W'(1);
    end else begin
      pre <= pre + PS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  pwm_o <= 1'b1;
    else if (!trig && !smooth) pwm_o <= 1'b1;
    else                      pwm_o <= act.pol_norm ? wave : ~wave;
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 6,
  parameter int LAT = 8,
  localparam int AW = $clog2(2 + 2*NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    pwm_out
);
  wave_cfg_t [NCH-1:0] cfg;
  logic [NCH-1:0]      ctl_trig, ctl_smooth;

  pwm_bank_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cfg(cfg), .trig(ctl_trig),
    .smooth(ctl_smooth)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_bank_chan #(.LAT(LAT)) u_chan (
      .clk(clk), .rst(rst), .shadow(cfg[c]), .trig(ctl_trig[c]),
      .smooth(ctl_smooth[c]), .pwm_o(pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 6,
  parameter int AW  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic [DATA_W-1:0] rdata,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH-1:0]    trig,
  input logic [NCH-1:0]    smooth
);
  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m = '0;
    for (int c = 0; c < NCH; c++) begin
      m[c] = 1'b1; m[8+c] = 1'b1; m[16+c] = 1'b1; m[24+c] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] ps_mask();
    logic [DATA_W-1:0] m = '0;
    for (int c = 0; c < NCH; c++)
      for (int j = 0; j < PS_W; j++) m[4*c+j] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_M = ctrl_mask();
  localparam logic [DATA_W-1:0] PS_M   = ps_mask();
  localparam logic [DATA_W-1:0] CNT_M  = DATA_W'({CNT_W{1'b1}});

  // R6: a channel left with trigger and smooth low is driven high
  p_idle_high_r6: assert property (@(posedge clk) disable iff (rst)
    ((~pwm_out) & $past(~trig & ~smooth)) == '0);

  // R2: no read strobe, no read data
  p_rd_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> rdata == '0);

  // R2: unimplemented control bits read zero
  p_ctrl_rsv_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(addr) == '0) |-> (rdata & ~CTRL_M) == '0);

  // R2: unimplemented prescale bits read zero
  p_ps_rsv_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(addr) == AW'(1)) |-> (rdata & ~PS_M) == '0);

  // R2: count registers are 24 bits wide
  p_cnt_rsv_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(addr) >= AW'(2)) |-> (rdata & ~CNT_M) == '0);
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .pwm_out(pwm_out), .trig(ctl_trig), .smooth(ctl_smooth)
);

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;
  localparam int LAT = 8;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  pwm_out;

  int n_chk = 0, n_fail = 0;
  logic [31:0] ctl_img = '0, ps_img = '0;

  pwm_bank #(.NCH(NCH), .LAT(LAT)) u_pwm_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = a[3:0]; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_en = 1'b1; addr = a[3:0];
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  function automatic logic exp_bit(input int ps, input int per, input int duty,
                                   input int pol, input int k);
    logic w;
    w = (per >= 2) && (((k / (ps + 1)) % per) < duty);
    return pol != 0 ? w : ~w;
  endfunction

  // program a channel and trigger it without smooth; sample nsamp cycles
  task automatic run_cfg(input int ch, input int ps, input int per,
                         input int duty, input int pol, input int nsamp);
    string tag;
    logic [5:0] ev;
    ctl_img[24+ch] = 1'b1; ctl_img[ch] = 1'b0;
    wr(0, ctl_img);
    ps_img[4*ch +: 3] = ps[2:0];
    wr(1, ps_img);
    wr(2 + 2*ch, per);
    wr(3 + 2*ch, duty);
    ctl_img[8+ch] = pol[0]; ctl_img[24+ch] = 1'b0; ctl_img[ch] = 1'b1;
    wr(0, ctl_img);
    repeat (LAT + 2) @(negedge clk);
    if (per < 2)                        tag = "R9";
    else if (duty == 0 || duty >= per)  tag = "R8";
    else if (pol == 0)                  tag = "R10";
    else                                tag = "R7";
    for (int k = 0; k < nsamp; k++) begin
      ev = pwm_out;
      ev[ch] = exp_bit(ps, per, duty, pol, k);
      chk(pwm_out[ch] == ev[ch], tag, 32'(pwm_out[ch]), 32'(ev[ch]));
      ev = '1;
      ev[ch] = pwm_out[ch];
      chk(pwm_out == ev, "R11", 32'(pwm_out), 32'(ev));
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int per_l[5];
    int dl[5];
    per_l = '{0, 1, 2, 3, 5};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(pwm_out == 6'h3f, "R1", 32'(pwm_out), 32'h3f);
    chk(rdata == 0, "R1", rdata, 0);
    for (int a = 0; a < 14; a++) begin
      rd(a, d);
      chk(d == 0, "R1", d, 0);
    end

    // R2 register map and readback
    wr(0, 32'hFFFF_FFFF); rd(0, d); chk(d == 32'h3F3F_3F3F, "R2", d, 32'h3F3F_3F3F);
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk(d == 32'h0077_7777, "R2", d, 32'h0077_7777);
    wr(8, 32'hFFAB_CDEF); rd(8, d); chk(d == 32'h00AB_CDEF, "R2", d, 32'h00AB_CDEF);
    wr(11, 32'h1234_5678); rd(11, d); chk(d == 32'h0034_5678, "R2", d, 32'h0034_5678);
    rd(15, d); chk(d == 0, "R2", d, 0);
    chk(rdata == 0, "R2", rdata, 0);
    rd(8, d); @(negedge clk); chk(rdata == 0, "R2", rdata, 0);
    wr(0, 0); wr(1, 0); ctl_img = '0; ps_img = '0;
    for (int a = 2; a < 14; a++) wr(a, 0);
    repeat (2) @(negedge clk);

    // R7..R11 sweep on channel 0
    for (int ps = 0; ps < 3; ps++)
      for (int pi = 0; pi < 5; pi++) begin
        dl = '{0, 1, 2, per_l[pi], per_l[pi] + 1};
        for (int di = 0; di < 5; di++)
          for (int pol = 0; pol < 2; pol++)
            run_cfg(0, ps, per_l[pi], dl[di], pol, 2 * per_l[pi] * (ps + 1) + 2);
      end
    ctl_img[0] = 1'b0; ctl_img[8] = 1'b0; wr(0, ctl_img);
    @(negedge clk);
    chk(pwm_out == 6'h3f, "R6", 32'(pwm_out), 32'h3f);

    // reduced sweep on the top channel
    for (int ps = 0; ps < 3; ps += 2)
      for (int du = 1; du < 4; du += 2)
        run_cfg(5, ps, 3, du, 1, 14);
    ctl_img[5] = 1'b0; ctl_img[13] = 1'b0; wr(0, ctl_img);
    @(negedge clk);

    // R3 and R4 on channel 1
    run_cfg(1, 0, 4, 0, 1, 0);
    ctl_img[25] = 1'b1; ctl_img[1] = 1'b0; wr(0, ctl_img);
    wr(5, 4);
    ctl_img[9] = 1'b0; wr(0, ctl_img);
    for (int i = 0; i < 12; i++) begin
      chk(pwm_out[1] == 1'b0, "R3", 32'(pwm_out[1]), 0);
      @(negedge clk);
    end
    ctl_img[9] = 1'b1; ctl_img[25] = 1'b0; ctl_img[1] = 1'b1; wr(0, ctl_img);
    repeat (LAT + 1) @(negedge clk);
    chk(pwm_out[1] == 1'b0, "R4", 32'(pwm_out[1]), 0);
    @(negedge clk);
    chk(pwm_out[1] == 1'b1, "R4", 32'(pwm_out[1]), 1);

    // R6 on channel 2: constant low, then release to idle
    run_cfg(2, 0, 4, 0, 1, 3);
    ctl_img[2] = 1'b0; ctl_img[26] = 1'b0; wr(0, ctl_img);
    chk(pwm_out[2] == 1'b0, "R6", 32'(pwm_out[2]), 0);
    @(negedge clk);
    chk(pwm_out[2] == 1'b1, "R6", 32'(pwm_out[2]), 1);

    // R5 on channel 3: smooth commit lands on the period wrap
    run_cfg(3, 0, 8, 8, 1, 0);
    ctl_img[27] = 1'b1; ctl_img[3] = 1'b0; wr(0, ctl_img);
    wr(9, 0);
    ctl_img[3] = 1'b1; wr(0, ctl_img);
    for (int k = 3; k < 12; k++) begin
      chk(pwm_out[3] == (k <= 7), "R5", 32'(pwm_out[3]), 32'(k <= 7));
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule